// File: doc/BRIEF.md
# Tag-Preserving Capability Memory

This block is an on-chip memory that keeps one hidden validity bit beside every 16-byte (128-bit) word. The validity bit says whether the word currently holds a genuine capability. Only the capability port can set or read it. Ordinary code cannot reach it. The block keeps the bit honest: any ordinary byte write that lands inside a word clears that word's bit. Data built up through plain stores can therefore never come back out of memory as a valid capability.

There are two write paths and one read path.

- **Capability store.** Writes a whole aligned 128-bit word together with the validity bit supplied with it. A store to an address that is not 16-byte aligned is refused and flagged.
- **Ordinary data store.** Writes 1, 2, 4 or 8 bytes at any byte address. A store that crosses a 16-byte boundary touches two words.
- **Read.** Returns a whole word one cycle after the request. A capability read also returns the validity bit. An ordinary read always shows the bit as 0.

Top module: `tagged_mem`

## Requirements
- R1: After reset every word's validity bit is 0, so a capability read of any word returns `rd_tag` = 0.
- R2: A capability store with `cwr_addr[3:0]` = 0 writes all 128 bits of `cwr_data` into word `cwr_addr[AW-1:4]` and sets its validity bit to `cwr_tag`. A later capability read of that word returns both the data and the bit.
- R3: A capability store with `cwr_tag` = 0 over a word whose bit is 1 leaves the bit at 0.
- R4: A capability store with `cwr_addr[3:0]` ≠ 0 raises `cwr_err` in the following cycle and changes neither data nor validity bits. `cwr_err` is 0 in every other cycle.
- R5: An ordinary read (`rd_cap` = 0) returns the word's data with `rd_tag` = 0, even when the word's bit is 1.
- R6: A data store of size code `dwr_size` (0,1,2,3 meaning 1,2,4,8 bytes) writes byte k of the store, `dwr_data[8k+7:8k]`, to byte address `dwr_addr+k` (little-endian). The word's byte j lives at `rd_data[8j+7:8j]`. All other bytes are left unchanged. Addresses wrap from the last byte of the array to byte 0.
- R7: A data store clears the validity bit of every word that holds at least one of its bytes. This includes both words when the store crosses a 16-byte boundary, and word 0 when it wraps. A data store never sets a bit.
- R8: `rd_vld` is high exactly in the cycle after `rd_valid`, and `rd_data`/`rd_tag` are valid then. A read and a write to the same word in the same cycle return the contents from before the write.
- R9: When a capability store and a data store arrive in the same cycle, both take effect. Where their bytes overlap, the data store's bytes win, and the bit of every word the data store touches ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cwr_valid | input | 1 | Capability store request |
| cwr_addr | input | AW | Byte address of the capability store |
| cwr_data | input | 128 | Capability contents |
| cwr_tag | input | 1 | Validity bit stored with the capability |
| cwr_err | output | 1 | Misaligned capability store refused (one cycle after the request) |
| dwr_valid | input | 1 | Ordinary data store request |
| dwr_addr | input | AW | Byte address of the first stored byte |
| dwr_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| dwr_data | input | 64 | Store bytes, byte 0 in bits 7:0 |
| rd_valid | input | 1 | Read request |
| rd_cap | input | 1 | 1 = capability read (bit visible), 0 = ordinary read |
| rd_idx | input | IDX_W | Word index to read |
| rd_vld | output | 1 | Read result valid |
| rd_data | output | 128 | Word contents |
| rd_tag | output | 1 | Validity bit (capability reads only, else 0) |

## Verification
The properties assume that `rst_n` is held low through at least one rising edge before any request. They also assume that request inputs change only between clock edges, so that each one is a clean one-cycle pulse. The bench drives every input on the falling edge and starts traffic only after releasing reset.

Every request is a single-cycle pulse that is dropped on the next falling edge. The bench therefore never depends on back-to-back behaviour that the properties do not describe. The bench's own tracking of data is valid only once every word has been written. For that reason, before that point, reads check only the validity bit.

// File: rtl/tmem_pkg.sv
package tmem_pkg;
  localparam int WORD_BITS  = 128;
  localparam int WORD_BYTES = WORD_BITS / 8;
  localparam int OFS_W      = $clog2(WORD_BYTES);
  localparam int DST_BITS   = 64;
  localparam int SIZE_W     = 2;
  localparam int WIN_BYTES  = 2 * WORD_BYTES;
  localparam int WIN_BITS   = 2 * WORD_BITS;

  // Byte lanes enabled by a data store across a two-word window.
  function automatic logic [WIN_BYTES-1:0] lane_window(
    input logic [OFS_W-1:0]  ofs,
    input logic [SIZE_W-1:0] size
  );
    logic [7:0] base;
    case (size)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0F;
      default: base = 8'hFF;
    endcase
    return {{(WIN_BYTES-8){1'b0}}, base} << ofs;
  endfunction

  // Store bytes placed at their lanes across the same window.
  function automatic logic [WIN_BITS-1:0] data_window(
    input logic [OFS_W-1:0]    ofs,
    input logic [DST_BITS-1:0] d
  );
    return {{(WIN_BITS-DST_BITS){1'b0}}, d} << {ofs, 3'b000};
  endfunction
endpackage

// File: rtl/tmem_dstore_decode.sv
module tmem_dstore_decode
  import tmem_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AW    = IDX_W + OFS_W
) (
  input  logic                                 dwr_valid,
  input  logic [AW-1:0]                        dwr_addr,
  input  logic [SIZE_W-1:0]                    dwr_size,
  input  logic [DST_BITS-1:0]                  dwr_data,
  output logic [DEPTH-1:0][WORD_BYTES-1:0]     word_be,
  output logic [DEPTH-1:0][WORD_BITS-1:0]      word_data,
  output logic [DEPTH-1:0]                     word_clr
);
  logic [IDX_W-1:0]     base_idx;
  logic [IDX_W-1:0]     next_idx;
  logic [WIN_BYTES-1:0] lanes;
  logic [WIN_BITS-1:0]  dwin;

  assign base_idx = dwr_addr[AW-1:OFS_W];
  assign next_idx = base_idx + IDX_W'(1);
  assign lanes    = lane_window(dwr_addr[OFS_W-1:0], dwr_size);
  assign dwin     = data_window(dwr_addr[OFS_W-1:0], dwr_data);

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit_lo;
    logic hit_hi;
    assign hit_lo = dwr_valid && (base_idx == IDX_W'(i));
    assign hit_hi = dwr_valid && (next_idx == IDX_W'(i));
    assign word_be[i] = (hit_lo ? lanes[WORD_BYTES-1:0] : '0)
                      | (hit_hi ? lanes[WIN_BYTES-1:WORD_BYTES] : '0);
    assign word_data[i] = hit_lo ? dwin[WORD_BITS-1:0] : dwin[WIN_BITS-1:WORD_BITS];
    assign word_clr[i]  = |word_be[i];
  end
endmodule

// File: rtl/tmem_tag_array.sv
module tmem_tag_array #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             set_val,
  input  logic [DEPTH-1:0] clr,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output wire  [DEPTH-1:0] tags_q,
  output logic             rd_tag_q
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_tag
    logic t_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  t_q <= 1'b0;
      else if (clr[i])                             t_q <= 1'b0;
      else if (set_en && set_idx == IDX_W'(i))     t_q <= set_val;
    end
    assign tags_q[i] = t_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_tag_q <= 1'b0;
    else if (rd_en) rd_tag_q <= tags_q[rd_idx];
  end
endmodule

// File: rtl/tmem_byte_ram.sv
module tmem_byte_ram
  import tmem_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cap_we,
  input  logic [IDX_W-1:0]                 cap_idx,
  input  logic [WORD_BITS-1:0]             cap_data,
  input  logic [DEPTH-1:0][WORD_BYTES-1:0] d_be,
  input  logic [DEPTH-1:0][WORD_BITS-1:0]  d_data,
  input  logic                             rd_en,
  input  logic [IDX_W-1:0]                 rd_idx,
  output logic [WORD_BITS-1:0]             rd_q
);
  wire [DEPTH-1:0][WORD_BITS-1:0] rows;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic cap_hit;
    assign cap_hit = cap_we && (cap_idx == IDX_W'(i));
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
      logic [7:0] cell_q;
      // data store bytes take precedence over a same-cycle capability store
      always_ff @(posedge clk) begin
        if (d_be[i][b])   cell_q <= d_data[i][b*8 +: 8];
        else if (cap_hit) cell_q <= cap_data[b*8 +: 8];
      end
      assign rows[i][b*8 +: 8] = cell_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rows[rd_idx];
  end
endmodule

// File: rtl/tagged_mem.sv
module tagged_mem
  import tmem_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AW    = IDX_W + OFS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cwr_valid,
  input  logic [AW-1:0]        cwr_addr,
  input  logic [WORD_BITS-1:0] cwr_data,
  input  logic                 cwr_tag,
  output logic                 cwr_err,
  input  logic                 dwr_valid,
  input  logic [AW-1:0]        dwr_addr,
  input  logic [SIZE_W-1:0]    dwr_size,
  input  logic [DST_BITS-1:0]  dwr_data,
  input  logic                 rd_valid,
  input  logic                 rd_cap,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic                 rd_vld,
  output logic [WORD_BITS-1:0] rd_data,
  output logic                 rd_tag
);
  // internal events brought out for the checker
  logic                             cap_ok;
  logic                             cap_mis;
  logic [IDX_W-1:0]                 cap_idx;
  logic [DEPTH-1:0][WORD_BYTES-1:0] dbe;
  logic [DEPTH-1:0][WORD_BITS-1:0]  dwd;
  logic [DEPTH-1:0]                 dclr;
  wire  [DEPTH-1:0]                 tags_q;
  logic                             tag_rd_q;
  logic                             rd_cap_q;
  logic                             err_q;
  logic                             vld_q;

  assign cap_mis = cwr_valid && (cwr_addr[OFS_W-1:0] != '0);
  assign cap_ok  = cwr_valid && !cap_mis;
  assign cap_idx = cwr_addr[AW-1:OFS_W];

  tmem_dstore_decode #(.DEPTH(DEPTH)) u_dec (
    .dwr_valid (dwr_valid),
    .dwr_addr  (dwr_addr),
    .dwr_size  (dwr_size),
    .dwr_data  (dwr_data),
    .word_be   (dbe),
    .word_data (dwd),
    .word_clr  (dclr)
  );

  tmem_tag_array #(.DEPTH(DEPTH)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (cap_ok),
    .set_idx  (cap_idx),
    .set_val  (cwr_tag),
    .clr      (dclr),
    .rd_en    (rd_valid),
    .rd_idx   (rd_idx),
    .tags_q   (tags_q),
    .rd_tag_q (tag_rd_q)
  );

  tmem_byte_ram #(.DEPTH(DEPTH)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_we   (cap_ok),
    .cap_idx  (cap_idx),
    .cap_data (cwr_data),
    .d_be     (dbe),
    .d_data   (dwd),
    .rd_en    (rd_valid),
    .rd_idx   (rd_idx),
    .rd_q     (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q    <= 1'b0;
      vld_q    <= 1'b0;
      rd_cap_q <= 1'b0;
    end else begin
      err_q    <= cap_mis;
      vld_q    <= rd_valid;
      if (rd_valid) rd_cap_q <= rd_cap;
    end
  end

  assign cwr_err = err_q;
  assign rd_vld  = vld_q;
  assign rd_tag  = rd_cap_q && tag_rd_q;
endmodule

// File: rtl/tmem_checker.sv
module tmem_checker #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int AW    = IDX_W + 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cwr_valid,
  input logic [AW-1:0]    cwr_addr,
  input logic             cwr_tag,
  input logic             cwr_err,
  input logic             rd_valid,
  input logic             rd_vld,
  input logic             rd_cap_q,
  input logic             rd_tag,
  input logic             cap_ok,
  input logic [IDX_W-1:0] cap_idx,
  input logic [DEPTH-1:0] dclr,
  input logic [DEPTH-1:0] tags_q
);
  AST_CAP_TAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ok && !dclr[cap_idx]) |=> (tags_q[$past(cap_idx)] == $past(cwr_tag))); // R2
  AST_DATA_CLEARS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (dclr != '0) |=> ((tags_q & $past(dclr)) == '0)); // R7
  AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_valid && cwr_addr[3:0] != 4'd0) |=> cwr_err); // R4
  AST_ERR_ONLY_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cwr_valid || cwr_addr[3:0] == 4'd0) |=> !cwr_err); // R4
  AST_MISALIGN_TAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_valid && cwr_addr[3:0] != 4'd0 && dclr == '0) |=> $stable(tags_q)); // R4
  AST_PLAIN_READ_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && !rd_cap_q) |-> !rd_tag); // R5
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_vld); // R8
  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_vld); // R8
endmodule

bind tagged_mem tmem_checker #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cwr_valid (cwr_valid),
  .cwr_addr  (cwr_addr),
  .cwr_tag   (cwr_tag),
  .cwr_err   (cwr_err),
  .rd_valid  (rd_valid),
  .rd_vld    (rd_vld),
  .rd_cap_q  (rd_cap_q),
  .rd_tag    (rd_tag),
  .cap_ok    (cap_ok),
  .cap_idx   (cap_idx),
  .dclr      (dclr),
  .tags_q    (tags_q)
);

// File: tb/tagged_mem_bench.sv
module tagged_mem_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int IDX_W = 2;
  localparam int AW    = 6;
  localparam int NBYTE = DEPTH * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cwr_valid = 0, cwr_tag = 0, cwr_err;
  logic [AW-1:0] cwr_addr = '0;
  logic [127:0] cwr_data = '0;
  logic dwr_valid = 0;
  logic [AW-1:0] dwr_addr = '0;
  logic [1:0] dwr_size = '0;
  logic [63:0] dwr_data = '0;
  logic rd_valid = 0, rd_cap = 0, rd_vld, rd_tag;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [127:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem_m [NBYTE];
  logic tag_m [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  tagged_mem #(.DEPTH(DEPTH)) u_tagged_mem (
    .clk(clk), .rst_n(rst_n),
    .cwr_valid(cwr_valid), .cwr_addr(cwr_addr), .cwr_data(cwr_data),
    .cwr_tag(cwr_tag), .cwr_err(cwr_err),
    .dwr_valid(dwr_valid), .dwr_addr(dwr_addr), .dwr_size(dwr_size),
    .dwr_data(dwr_data),
    .rd_valid(rd_valid), .rd_cap(rd_cap), .rd_idx(rd_idx),
    .rd_vld(rd_vld), .rd_data(rd_data), .rd_tag(rd_tag)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] pat(input int s);
    logic [127:0] v;
    for (int k = 0; k < 4; k++)
      v[k*32 +: 32] = 32'((s * 4 + k + 1) * 32'h9E3779B1) ^ 32'h5A5A1234;
    return v;
  endfunction

  function automatic logic [127:0] model_word(input int w);
    logic [127:0] v;
    for (int j = 0; j < 16; j++) v[j*8 +: 8] = mem_m[w*16 + j];
    return v;
  endfunction

  function automatic void model_cap(input int w, input logic [127:0] d, input logic t);
    for (int j = 0; j < 16; j++) mem_m[w*16 + j] = d[j*8 +: 8];
    tag_m[w] = t;
  endfunction

  function automatic void model_data(input int a, input int sz, input logic [63:0] d);
    for (int k = 0; k < (1 << sz); k++) begin
      int ad = (a + k) % NBYTE;
      mem_m[ad] = d[k*8 +: 8];
      tag_m[ad / 16] = 1'b0;
    end
  endfunction

  task automatic cap_store(input int a, input logic [127:0] d, input logic t);
    @(negedge clk);
    cwr_valid = 1; cwr_addr = AW'(a); cwr_data = d; cwr_tag = t;
    @(negedge clk);
    cwr_valid = 0;
    chk(cwr_err == ((a % 16) != 0), "R4 err flag", {127'd0, cwr_err}, {127'd0, (a % 16) != 0});
    if (a % 16 == 0) model_cap(a / 16, d, t);
  endtask

  task automatic data_store(input int a, input int sz, input logic [63:0] d);
    @(negedge clk);
    dwr_valid = 1; dwr_addr = AW'(a); dwr_size = 2'(sz); dwr_data = d;
    @(negedge clk);
    dwr_valid = 0;
    model_data(a, sz, d);
  endtask

  task automatic read_word(input int w, input logic cap, input bit cmp_data,
                           input string rq_d, input string rq_t);
    @(negedge clk);
    rd_valid = 1; rd_cap = cap; rd_idx = IDX_W'(w);
    @(negedge clk);
    rd_valid = 0;
    chk(rd_vld === 1'b1, "R8 valid", {127'd0, rd_vld}, 128'd1);
    if (cmp_data) chk(rd_data === model_word(w), rq_d, rd_data, model_word(w));
    chk(rd_tag === (cap & tag_m[w]), rq_t, {127'd0, rd_tag}, {127'd0, cap & tag_m[w]});
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int w = 0; w < DEPTH; w++) tag_m[w] = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cwr_err === 1'b0, "R1 err at reset", {127'd0, cwr_err}, 128'd0);
    chk(rd_vld === 1'b0, "R1 vld at reset", {127'd0, rd_vld}, 128'd0);
    rst_n = 1'b1;
    for (int w = 0; w < DEPTH; w++) read_word(w, 1'b1, 1'b0, "R1", "R1 tag after reset");
    @(negedge clk);
    chk(rd_vld === 1'b0, "R8 vld idle", {127'd0, rd_vld}, 128'd0);

    // R2 capability store and load
    for (int w = 0; w < DEPTH; w++) cap_store(w * 16, pat(w), 1'b1);
    for (int w = 0; w < DEPTH; w++) read_word(w, 1'b1, 1'b1, "R2 data", "R2 tag");
    // R5 ordinary read hides tag
    for (int w = 0; w < DEPTH; w++) read_word(w, 1'b0, 1'b1, "R5 data", "R5 tag hidden");
    // R3 storing an invalid capability clears
    cap_store(32, pat(40), 1'b0);
    read_word(2, 1'b1, 1'b1, "R3 data", "R3 tag cleared");
    cap_store(32, pat(41), 1'b1);
    // R4 misaligned stores refused, memory unchanged
    for (int o = 1; o < 16; o += 5) begin
      cap_store(16 + o, pat(50 + o), 1'b0);
      read_word(1, 1'b1, 1'b1, "R4 data kept", "R4 tag kept");
    end
    @(negedge clk);
    chk(cwr_err === 1'b0, "R4 err drops", {127'd0, cwr_err}, 128'd0);

    // R8 read and write to same word in one cycle return old contents
    @(negedge clk);
    rd_valid = 1; rd_cap = 1; rd_idx = 2'd3;
    cwr_valid = 1; cwr_addr = 6'd48; cwr_data = pat(60); cwr_tag = 1'b0;
    @(negedge clk);
    rd_valid = 0; cwr_valid = 0;
    chk(rd_data === model_word(3), "R8 old data", rd_data, model_word(3));
    chk(rd_tag === tag_m[3], "R8 old tag", {127'd0, rd_tag}, {127'd0, tag_m[3]});
    model_cap(3, pat(60), 1'b0);
    read_word(3, 1'b1, 1'b1, "R8 new data", "R8 new tag");

    // R9 simultaneous capability and data store, overlapping word
    cap_store(48, pat(61), 1'b1);
    @(negedge clk);
    cwr_valid = 1; cwr_addr = 6'd16; cwr_data = pat(62); cwr_tag = 1'b1;
    dwr_valid = 1; dwr_addr = 6'd20; dwr_size = 2'd2; dwr_data = 64'h0123456789ABCDEF;
    @(negedge clk);
    cwr_valid = 0; dwr_valid = 0;
    model_cap(1, pat(62), 1'b1);
    model_data(20, 2, 64'h0123456789ABCDEF);
    read_word(1, 1'b1, 1'b1, "R9 merged data", "R9 tag cleared");
    // R9 different words: capability tag survives
    @(negedge clk);
    cwr_valid = 1; cwr_addr = 6'd32; cwr_data = pat(63); cwr_tag = 1'b1;
    dwr_valid = 1; dwr_addr = 6'd3; dwr_size = 2'd0; dwr_data = 64'hA5;
    @(negedge clk);
    cwr_valid = 0; dwr_valid = 0;
    model_cap(2, pat(63), 1'b1);
    model_data(3, 0, 64'hA5);
    read_word(2, 1'b1, 1'b1, "R9 other data", "R9 other tag kept");
    read_word(0, 1'b1, 1'b1, "R9 data word", "R9 data word tag");

    // R6/R7 sweep over every byte address and size
    for (int a = 0; a < NBYTE; a++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int w = 0; w < DEPTH; w++) cap_store(w * 16, pat(a * 8 + sz * 2 + w), 1'b1);
        data_store(a, sz, pat(a * 4 + sz + 1000)[63:0]);
        for (int w = 0; w < DEPTH; w++)
          read_word(w, 1'b1, 1'b1, "R6 byte placement", "R7 tag clear");
      end
    end
    finish_run();
  end
endmodule